// File: doc/BRIEF.md
# Latency-Aligned Result Write-Back Scheduler

This block sits between a set of functional units whose results take different numbers of issue steps to appear and a register file with a single write port. It keeps a small ring of result slots, one per step of the longest latency. Each time an instruction issues, the slot under the ring's read pointer is handed to the register file. The target register is the destination field of the instruction issuing in that same step, not the field of the instruction that produced the value. The compiler therefore has to place each destination exactly as many issue steps after its producer as that producer's latency.

Within one issue step the work has a fixed order. First the slot under the read pointer is drained to the write port, unless the destination is register 0. Then that slot is cleared and the pointer moves on, wrapping modulo the ring depth. Last, the new result from a compute instruction is written L−1 slots past the moved pointer, where L is its latency. A no-op drains and advances but stores nothing. A vector-output instruction leaves the ring untouched and raises the end-of-program strobe. If a store lands on a slot that still holds an undrained value, the new value replaces it and a collision counter steps.

Top module: `wb_sched_queue`

## Requirements
- R1: A synchronous active-low reset empties every slot, puts the read pointer at slot 0 and clears the collision counter. After reset, the first drain returns 0.
- R2: On an issue of kind no-op (0), compute (1) or reserved (3), `rf_we` is high and `rf_waddr` equals `iss_dest` exactly when `iss_dest` is non-zero. `rf_wdata` is the value in the slot under the read pointer. Destination 0 writes nothing.
- R3: A compute result with latency L, where 1 ≤ L ≤ DEPTH, is the value drained on the L-th issue after its own issue, counting only issues that advance the ring.
- R4: A slot that has been drained and has not been refilled returns 0 when the read pointer comes back to it, after wrapping past the last slot.
- R5: A no-op (kind 0), and the reserved kind 3, store nothing in the ring even when `iss_result` and `iss_lat` carry values, but they still drain and advance.
- R6: A vector-output issue (kind 2) does not write the register file, does not advance the read pointer and stores nothing. `prog_end` is high in that issue cycle only.
- R7: A cycle with `iss_valid` low writes nothing and leaves the ring and the pointer unchanged.
- R8: A store into a slot that still holds an undrained value overwrites it, and `coll_count` rises by one.
- R9: A latency-DEPTH store targets the slot that was just drained. That slot counts as empty, so no collision is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | An instruction issues in this cycle |
| iss_kind | input | 2 | 0 no-op, 1 compute, 2 vector output, 3 treated as no-op |
| iss_lat | input | 3 | Latency of the compute result, 1 to DEPTH |
| iss_dest | input | 7 | Destination field of the issuing instruction, 0 means none |
| iss_result | input | 32 | Result value of the compute instruction |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 7 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data (slot under the read pointer) |
| prog_end | output | 1 | Vector-output issue seen; current program ends |
| coll_count | output | 16 | Number of stores that overwrote a pending value (wraps) |

## Verification
Two functions can meet in one slot in the same cycle: clearing the slot just drained, and storing a result whose latency equals the ring depth. The bench provokes this with a latency-7 compute issue. It judges the outcome by the value drained seven issues later and by the collision counter, which must not move. A second pairing is a store aimed at a slot that still holds an earlier result. The bench sets this up with a latency-3 issue followed by a latency-2 issue, so that both target one slot. The later value must come out at the drain, and the collision counter must read exactly one at the end of the sequence.

// File: rtl/wbq_pkg.sv
// Package: shared kinds for the write-back scheduler.
// Assumes the issue kind is carried on two bits.
package wbq_pkg;
    typedef enum logic [1:0] {
        KIND_NOP  = 2'd0,
        KIND_CALC = 2'd1,
        KIND_VOUT = 2'd2,
        KIND_RSVD = 2'd3
    } iss_kind_t;
endpackage

// File: rtl/wbq_slot_index.sv
// Module: wbq_slot_index
// Computes the slot a new result is stored in: (head + lat) mod DEPTH,
// which equals the advanced pointer plus lat-1. Assumes 1 <= lat <= DEPTH
// and head < DEPTH. A power-of-two depth uses a mask, any other depth a
// single compare-and-subtract.
module wbq_slot_index #(
    parameter int DEPTH = 7,
    parameter int HW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic [HW-1:0] head,
    input  logic [LW-1:0] lat,
    output logic [HW-1:0] idx
);
    localparam int SW = $clog2(2 * DEPTH) + 1;

    logic [SW-1:0] sum;

    // Purpose: raw sum of pointer and latency.
    always_comb sum = SW'(head) + SW'(lat);

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            // Purpose: wrap by dropping the upper bits.
            always_comb idx = sum[HW-1:0];
        end else begin : g_gen
            // Purpose: wrap by one conditional subtraction.
            always_comb idx = (sum >= SW'(DEPTH)) ? HW'(sum - SW'(DEPTH)) : HW'(sum);
        end
    endgenerate
endmodule

// File: rtl/wbq_slot_store.sv
// Module: wbq_slot_store
// Ring of DEPTH result slots with a read pointer. On adv the slot under
// the pointer is cleared and the pointer moves on; a store (ins_en) to a
// slot wins over its clearing. Assumes ins_en is only raised with adv.
module wbq_slot_store #(
    parameter int DEPTH = 7,
    parameter int XW    = 32,
    parameter int HW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          ins_en,
    input  logic [HW-1:0] ins_idx,
    input  logic [XW-1:0] ins_data,
    output logic [HW-1:0] head,
    output logic [XW-1:0] head_data,
    output logic          target_busy
);
    logic [XW-1:0] dat_w [DEPTH];
    logic          vld_w [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            logic [XW-1:0] d_q;
            logic          v_q;

            // Purpose: hold one slot; store has priority over clearing.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_q <= '0;
                    v_q <= 1'b0;
                end else if (ins_en && ins_idx == HW'(g)) begin
                    d_q <= ins_data;
                    v_q <= 1'b1;
                end else if (adv && head == HW'(g)) begin
                    d_q <= '0;
                    v_q <= 1'b0;
                end
            end

            assign dat_w[g] = d_q;
            assign vld_w[g] = v_q;
        end
    endgenerate

    // Purpose: move the read pointer on each advancing issue, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            head <= '0;
        else if (adv)
            head <= (head == HW'(DEPTH - 1)) ? '0 : head + 1'b1;
    end

    // Purpose: present the slot under the pointer.
    always_comb head_data = dat_w[head];

    // Purpose: a target is busy if pending and not the slot cleared now (R9).
    always_comb target_busy = vld_w[ins_idx] && !(adv && ins_idx == head);

    // R4: a drained slot that received no store is empty afterwards.
    p_drain_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !(ins_en && ins_idx == head)) |=> !vld_w[$past(head)]);

    // R7: without advance or store the pointer stays put.
    p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !ins_en) |=> $stable(head));

    // R3: a store leaves its slot holding the stored value.
    p_store_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> (vld_w[$past(ins_idx)] && dat_w[$past(ins_idx)] == $past(ins_data)));
endmodule

// File: rtl/wbq_hit_counter.sv
// Module: wbq_hit_counter
// Wrapping event counter for stores that overwrite a pending value.
module wbq_hit_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    output logic [CW-1:0] count
);
    // Purpose: count overwrite events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (hit)
            count <= count + 1'b1;
    end

    // R8: each overwrite steps the count by exactly one.
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> count == $past(count) + 1'b1);

    // R8: without an overwrite the count does not move.
    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(count));
endmodule

// File: rtl/wb_sched_queue.sv
// Module: wb_sched_queue (top)
// Aligns results of units with different latencies to a single
// register-file write port. Each issue drains the slot under the read
// pointer to the issuing instruction's destination, advances the ring,
// and stores a compute result (latency - 1) past the new pointer.
// Assumes compute latencies lie in 1..DEPTH; the bench-level caller
// schedules destinations to match producer latencies.
module wb_sched_queue
    import wbq_pkg::*;
#(
    parameter int DEPTH = 7,
    parameter int XW    = 32,
    parameter int DW    = 7,
    parameter int CW    = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [1:0]    iss_kind,
    input  logic [LW-1:0] iss_lat,
    input  logic [DW-1:0] iss_dest,
    input  logic [XW-1:0] iss_result,
    output logic          rf_we,
    output logic [DW-1:0] rf_waddr,
    output logic [XW-1:0] rf_wdata,
    output logic          prog_end,
    output logic [CW-1:0] coll_count
);
    localparam int HW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    iss_kind_t     kind;
    logic          adv;
    logic          ins_en;
    logic [HW-1:0] head;
    logic [HW-1:0] ins_idx;
    logic [XW-1:0] head_data;
    logic          target_busy;
    logic          hit;

    // Purpose: decode the issue kind into ring actions.
    always_comb begin
        kind     = iss_kind_t'(iss_kind);
        adv      = iss_valid && (kind != KIND_VOUT);
        ins_en   = iss_valid && (kind == KIND_CALC);
        prog_end = iss_valid && (kind == KIND_VOUT);
        hit      = ins_en && target_busy;
    end

    // Purpose: drive the register-file write port from the head slot.
    always_comb begin
        rf_we    = adv && (iss_dest != '0);
        rf_waddr = iss_dest;
        rf_wdata = head_data;
    end

    wbq_slot_index #(.DEPTH(DEPTH), .HW(HW), .LW(LW)) u_index (
        .head (head),
        .lat  (iss_lat),
        .idx  (ins_idx)
    );

    wbq_slot_store #(.DEPTH(DEPTH), .XW(XW), .HW(HW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .ins_en      (ins_en),
        .ins_idx     (ins_idx),
        .ins_data    (iss_result),
        .head        (head),
        .head_data   (head_data),
        .target_busy (target_busy)
    );

    wbq_hit_counter #(.CW(CW)) u_hits (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .count (coll_count)
    );

    // R6: a vector-output issue never writes the register file.
    p_vout_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_end |-> !rf_we);

    // R6: a vector-output issue leaves the read pointer where it was.
    p_vout_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_end |=> $stable(head));

    // R3: compute latencies stay inside the ring.
    p_lat_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> (iss_lat >= LW'(1) && iss_lat <= LW'(DEPTH)));

    // R2: a write never targets register 0.
    p_no_reg0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_waddr != '0);
endmodule

// File: tb/wb_sched_queue_bench.sv
module wb_sched_queue_bench;
    localparam int PERIOD = 10;
    localparam int NVEC   = 24;

    typedef struct packed {
        logic        v;
        logic [1:0]  kind;
        logic [2:0]  lat;
        logic [6:0]  dest;
        logic [31:0] res;
        logic        ewe;
        logic [31:0] edata;
        logic        eend;
    } vec_t;

    localparam logic [31:0] VA = 32'h1111_00A1, VB = 32'h2222_00B2,
                            VC = 32'h3333_00C3, VD = 32'h4444_00D4,
                            VE = 32'h5555_00E5, VF = 32'h6666_00F6,
                            VG = 32'h7777_0007, VH = 32'h8888_0008;

    // Steps walk the ring through wrap, vector output, collision and idle.
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 2'd1, 3'd3, 7'd0,  VA,    1'b0, 32'h0, 1'b0}, // 0 store at 3
        '{1'b1, 2'd1, 3'd1, 7'd0,  VB,    1'b0, 32'h0, 1'b0}, // 1 store at 2
        '{1'b1, 2'd0, 3'd0, 7'd5,  32'h0, 1'b1, VB,    1'b0}, // 2 R3 lat1
        '{1'b1, 2'd1, 3'd7, 7'd6,  VC,    1'b1, VA,    1'b0}, // 3 R3 lat3, R9 lat7
        '{1'b1, 2'd0, 3'd0, 7'd0,  32'h0, 1'b0, 32'h0, 1'b0}, // 4 R2 dest0
        '{1'b1, 2'd0, 3'd0, 7'd0,  32'h0, 1'b0, 32'h0, 1'b0}, // 5
        '{1'b1, 2'd0, 3'd0, 7'd0,  32'h0, 1'b0, 32'h0, 1'b0}, // 6 wrap
        '{1'b1, 2'd0, 3'd0, 7'd0,  32'h0, 1'b0, 32'h0, 1'b0}, // 7
        '{1'b1, 2'd0, 3'd0, 7'd0,  32'h0, 1'b0, 32'h0, 1'b0}, // 8
        '{1'b1, 2'd0, 3'd0, 7'd9,  32'h0, 1'b1, 32'h0, 1'b0}, // 9 R4 cleared
        '{1'b1, 2'd0, 3'd0, 7'd10, 32'h0, 1'b1, VC,    1'b0}, // 10 R9 lat7
        '{1'b1, 2'd1, 3'd2, 7'd0,  VD,    1'b0, 32'h0, 1'b0}, // 11
        '{1'b1, 2'd2, 3'd0, 7'd3,  32'h0, 1'b0, 32'h0, 1'b1}, // 12 R6 vout
        '{1'b1, 2'd0, 3'd0, 7'd7,  32'h0, 1'b1, 32'h0, 1'b0}, // 13 R6 no advance
        '{1'b1, 2'd0, 3'd0, 7'd8,  32'h0, 1'b1, VD,    1'b0}, // 14
        '{1'b1, 2'd1, 3'd3, 7'd0,  VE,    1'b0, 32'h0, 1'b0}, // 15
        '{1'b1, 2'd1, 3'd2, 7'd0,  VF,    1'b0, 32'h0, 1'b0}, // 16 R8 overwrite
        '{1'b1, 2'd0, 3'd0, 7'd0,  32'h0, 1'b0, 32'h0, 1'b0}, // 17
        '{1'b1, 2'd0, 3'd0, 7'd11, 32'h0, 1'b1, VF,    1'b0}, // 18 R8 newer wins
        '{1'b1, 2'd1, 3'd1, 7'd0,  VG,    1'b0, 32'h0, 1'b0}, // 19
        '{1'b0, 2'd0, 3'd0, 7'd14, 32'h0, 1'b0, 32'h0, 1'b0}, // 20 R7 idle
        '{1'b1, 2'd0, 3'd0, 7'd15, 32'h0, 1'b1, VG,    1'b0}, // 21 R7 held
        '{1'b1, 2'd0, 3'd1, 7'd0,  VH,    1'b0, 32'h0, 1'b0}, // 22 R5 nop data
        '{1'b1, 2'd0, 3'd0, 7'd16, 32'h0, 1'b1, 32'h0, 1'b0}  // 23 R5 nothing stored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_kind = 2'd0;
    logic [2:0]  iss_lat = 3'd0;
    logic [6:0]  iss_dest = 7'd0;
    logic [31:0] iss_result = 32'h0;
    logic        rf_we;
    logic [6:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        prog_end;
    logic [15:0] coll_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    wb_sched_queue u_wb_sched_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (iss_valid),
        .iss_kind   (iss_kind),
        .iss_lat    (iss_lat),
        .iss_dest   (iss_dest),
        .iss_result (iss_result),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .prog_end   (prog_end),
        .coll_count (coll_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic [2:0] l,
                         input logic [6:0] d, input logic [31:0] r);
        @(negedge clk);
        iss_valid  = v;
        iss_kind   = k;
        iss_lat    = l;
        iss_dest   = d;
        iss_result = r;
        #(PERIOD / 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(PERIOD / 5);
        chk("R1 count after reset", 32'(coll_count), 32'h0);
        chk("R1 no write when idle", 32'(rf_we), 32'h0);
        chk("R1 empty head", rf_wdata, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i].v, TBL[i].kind, TBL[i].lat, TBL[i].dest, TBL[i].res);
            chk($sformatf("R2 step %0d we", i), 32'(rf_we), 32'(TBL[i].ewe));
            if (TBL[i].ewe) begin
                chk($sformatf("R2 step %0d addr", i), 32'(rf_waddr), 32'(TBL[i].dest));
                chk($sformatf("R3 step %0d data", i), rf_wdata, TBL[i].edata);
            end
            chk($sformatf("R6 step %0d end", i), 32'(prog_end), 32'(TBL[i].eend));
        end
        chk("R8 R9 count after sequence", 32'(coll_count), 32'h1);

        // R5: reserved kind 3 stores nothing.
        drive(1'b1, 2'd3, 3'd1, 7'd0, 32'hDEAD_0003);
        drive(1'b1, 2'd0, 3'd0, 7'd17, 32'h0);
        chk("R5 reserved kind stores nothing", rf_wdata, 32'h0);

        // R1: reset mid-run drops a pending value and the count.
        drive(1'b1, 2'd1, 3'd1, 7'd0, 32'hCAFE_0001);
        rst_n = 1'b0;
        drive(1'b0, 2'd0, 3'd0, 7'd0, 32'h0);
        drive(1'b0, 2'd0, 3'd0, 7'd0, 32'h0);
        rst_n = 1'b1;
        chk("R1 count cleared", 32'(coll_count), 32'h0);
        drive(1'b1, 2'd0, 3'd0, 7'd18, 32'h0);
        chk("R1 pending dropped", rf_wdata, 32'h0);

        // R8: second overwrite on a fresh ring.
        drive(1'b1, 2'd1, 3'd2, 7'd0, 32'h0000_0A0A);
        drive(1'b1, 2'd1, 3'd1, 7'd0, 32'h0000_0B0B);
        drive(1'b1, 2'd0, 3'd0, 7'd19, 32'h0);
        chk("R8 overwrite value", rf_wdata, 32'h0000_0B0B);
        chk("R8 count", 32'(coll_count), 32'h1);

        drive(1'b0, 2'd0, 3'd0, 7'd0, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule